// File: doc/BRIEF.md
# Memory Read-Back Pattern Checker

This block walks a window of memory, issuing one read command per word and comparing each returned word with a value taken from an internal pseudo-random sequence. The sequence restarts from a fixed seed at every fresh run. A write-side generator seeded the same way fills the window with the same sequence, so a healthy memory reads back without a single mismatch.

Software loads a base word address, a length in words and a halt-on-error enable, and then pulses start. Mismatches are counted. The absolute address, the expected word and the received word of the reported mismatch are kept for inspection. With halt-on-error clear, the run always reaches the end and the captured details belong to the last mismatch. With halt-on-error set, the run stops at each mismatch. The next start then resumes at the following word, and the error count keeps its value across the halt.

Top module: `mem_pattern_checker`

## Requirements
- R1: After reset, `stat_done`, `stat_running`, `rd_cmd_valid` and `stat_err_count` are all zero.
- R2: A run issues exactly one read command per word. Addresses rise by one, from the base to base+length-1. A run of length zero finishes without issuing any command.
- R3: The expected value for word i of a run is term i of the sequence s0 = SEED (default 32'h13579BDF), s(n+1) = {s(n)[30:0], s(n)[31]^s(n)[21]^s(n)[1]^s(n)[0]}. The sequence restarts at s0 on every fresh start and advances once per compared word.
- R4: With halt-on-error clear, every mismatch increments the error count and the run continues to its end. The error address, expected word and actual word then describe the most recent mismatch. The error address is absolute, not relative to the base.
- R5: With halt-on-error set, the first mismatch stops the run. After any read data still in flight is discarded without comparison, `stat_done` is 1 and `stat_running` is 0, and the mismatch's address, expected word and actual word are held.
- R6: A start strobe while halted resumes at the word after the failing one, continuing the same sequence. The error count keeps accumulating from its held value.
- R7: A start strobe while idle or after a completed run begins a fresh run. It clears the error count and the captured details, and it latches base, length and halt enable.
- R8: `stat_done` stays high from the end or halt of a run until the next start strobe. A start strobe while running or draining has no effect.
- R9: `rd_cmd_valid` is asserted only while running. Once asserted without `rd_cmd_ready`, it stays high with a stable address until accepted, unless the run halts. No more than MAX_OUT reads are outstanding, so commands issued never fall below data words consumed.
- R10: The error count saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | First word address of the window |
| cfg_len | input | LW | Number of words to check |
| cfg_start | input | 1 | Single-cycle start / resume strobe |
| cfg_halt_en | input | 1 | Stop at each mismatch when set |
| rd_cmd_valid | output | 1 | Read command valid |
| rd_cmd_ready | input | 1 | Read command accepted by the port |
| rd_cmd_addr | output | AW | Read command word address |
| rd_data_valid | input | 1 | Read data word present (always consumed) |
| rd_data | input | DW | Read data word |
| stat_done | output | 1 | Run ended or halted |
| stat_running | output | 1 | Run in progress |
| stat_err_count | output | CW | Saturating mismatch count |
| stat_err_addr | output | AW | Absolute address of the reported mismatch |
| stat_err_expect | output | DW | Expected word of the reported mismatch |
| stat_err_actual | output | DW | Received word of the reported mismatch |

## Verification
The bound checker watches, on every cycle, that done and running are never both high, that a command stays valid and keeps its address while it is back-pressured, that commands appear only while running, and that the outstanding read count never exceeds its limit. It also checks that done holds until a start and that the error count never falls or leaves saturation unless a start arrives. Only the directed scenarios can show the actual pattern values, that a resume lands on the word after the failing one, that in-flight data is thrown away during a halt, and that mismatches are counted and captured correctly. For those, the bench corrupts chosen memory words and compares the results against its own model of the sequence.

// File: rtl/mpc_pkg.sv
// Shared types for the memory pattern checker.
// Assumes: nothing beyond a single clock domain.
package mpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_HALT  = 3'd3,
        ST_DONE  = 3'd4
    } mpc_state_t;

    localparam int PAT_W = 32;
endpackage

// File: rtl/mpc_lfsr.sv
// 32-bit maximal-length pattern source (taps 32,22,2,1).
// Reloads SEED on reseed; steps once per advance. Assumes SEED != 0.
module mpc_lfsr #(
    parameter logic [31:0] SEED = 32'h13579BDF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reseed,
    input  logic        advance,
    output logic [31:0] value
);
    logic fb;

    // Feedback bit from the tap positions.
    always_comb fb = value[31] ^ value[21] ^ value[1] ^ value[0];

    // Pattern register: seed on reset or reseed, shift on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) value <= SEED;
        else if (advance)     value <= {value[30:0], fb};
    end
endmodule

// File: rtl/mpc_issue.sv
// Read command issuer: walks word indices of the window and tracks reads in flight.
// Assumes: data returns in order, one word per command; every valid data beat
// while reads are outstanding answers the oldest one.
module mpc_issue #(
    parameter int AW      = 32,
    parameter int LW      = 16,
    parameter int MAX_OUT = 4,
    localparam int OCW    = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load,
    input  logic [LW-1:0] load_idx,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic          data_beat,
    input  logic          cmd_ready,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [OCW-1:0] inflight
);
    logic [LW-1:0] cmd_idx;
    logic          hs;
    logic          ret;

    // Command request and address, derived from registered state only.
    always_comb begin
        cmd_valid = enable && (cmd_idx < len) && (inflight < OCW'(MAX_OUT));
        cmd_addr  = base + AW'(cmd_idx);
        hs        = cmd_valid && cmd_ready;
        ret       = data_beat && (inflight != '0);
    end

    // Next word index to request.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmd_idx <= '0;
        else if (load) cmd_idx <= load_idx;
        else if (hs)   cmd_idx <= cmd_idx + 1'b1;
    end

    // Outstanding read count.
    always_ff @(posedge clk) begin
        if (!rst_n)          inflight <= '0;
        else if (hs && !ret) inflight <= inflight + 1'b1;
        else if (!hs && ret) inflight <= inflight - 1'b1;
    end
endmodule

// File: rtl/mpc_capture.sv
// Mismatch bookkeeping: saturating counter plus the details of the last mismatch.
// Assumes: clear and hit are never both high.
module mpc_capture #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          hit,
    input  logic [AW-1:0] hit_addr,
    input  logic [DW-1:0] hit_expect,
    input  logic [DW-1:0] hit_actual,
    output logic [CW-1:0] count,
    output logic [AW-1:0] err_addr,
    output logic [DW-1:0] err_expect,
    output logic [DW-1:0] err_actual
);
    // Saturating mismatch counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)         count <= '0;
        else if (hit && count != '1) count <= count + 1'b1;
    end

    // Details of the latest mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            err_addr   <= '0;
            err_expect <= '0;
            err_actual <= '0;
        end else if (hit) begin
            err_addr   <= hit_addr;
            err_expect <= hit_expect;
            err_actual <= hit_actual;
        end
    end
endmodule

// File: rtl/mem_pattern_checker.sv
// Memory read-back pattern checker top: run control, comparison, resume after halt.
// Assumes: AW >= LW, DW is at least 1; read data is accepted every cycle.
module mem_pattern_checker #(
    parameter int          AW      = 32,
    parameter int          DW      = 32,
    parameter int          LW      = 16,
    parameter int          CW      = 16,
    parameter int          MAX_OUT = 4,
    parameter logic [31:0] SEED    = 32'h13579BDF,
    localparam int         OCW     = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_start,
    input  logic          cfg_halt_en,
    output logic          rd_cmd_valid,
    input  logic          rd_cmd_ready,
    output logic [AW-1:0] rd_cmd_addr,
    input  logic          rd_data_valid,
    input  logic [DW-1:0] rd_data,
    output logic          stat_done,
    output logic          stat_running,
    output logic [CW-1:0] stat_err_count,
    output logic [AW-1:0] stat_err_addr,
    output logic [DW-1:0] stat_err_expect,
    output logic [DW-1:0] stat_err_actual
);
    import mpc_pkg::*;

    mpc_state_t     state;
    logic [AW-1:0]  base_q;
    logic [LW-1:0]  len_q;
    logic [LW-1:0]  dat_idx;
    logic           halt_q;
    logic [31:0]    lfsr_val;
    logic [DW-1:0]  expect_w;
    logic [OCW-1:0] inflight;
    logic start_ok, fresh, resume, run_end, take, miss, stop;

    // Expected word: pattern sized to the data width.
    generate
        if (DW <= PAT_W) begin : g_narrow
            assign expect_w = lfsr_val[DW-1:0];
        end else begin : g_wide
            assign expect_w = {{(DW-PAT_W){1'b0}}, lfsr_val};
        end
    endgenerate

    // Run control decode.
    always_comb begin
        start_ok = cfg_start && (state == ST_IDLE || state == ST_HALT || state == ST_DONE);
        fresh    = start_ok && (state != ST_HALT);
        resume   = start_ok && (state == ST_HALT);
        run_end  = (state == ST_RUN) && (dat_idx == len_q);
        take     = (state == ST_RUN) && !run_end && rd_data_valid;
        miss     = take && (rd_data != expect_w);
        stop     = miss && halt_q;
    end

    // Run state machine and compared-word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            base_q  <= '0;
            len_q   <= '0;
            dat_idx <= '0;
            halt_q  <= 1'b0;
        end else if (fresh) begin
            state   <= ST_RUN;
            base_q  <= cfg_base;
            len_q   <= cfg_len;
            dat_idx <= '0;
            halt_q  <= cfg_halt_en;
        end else if (resume) begin
            state   <= ST_RUN;
            halt_q  <= cfg_halt_en;
        end else if (run_end) begin
            state   <= ST_DONE;
        end else if (take) begin
            dat_idx <= dat_idx + 1'b1;
            if (stop) state <= ST_DRAIN;
        end else if (state == ST_DRAIN && inflight == '0) begin
            state   <= ST_HALT;
        end
    end

    mpc_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (fresh),
        .advance (take),
        .value   (lfsr_val)
    );

    mpc_issue #(.AW(AW), .LW(LW), .MAX_OUT(MAX_OUT)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state == ST_RUN),
        .load      (fresh || stop),
        .load_idx  (fresh ? '0 : dat_idx + 1'b1),
        .base      (base_q),
        .len       (len_q),
        .data_beat (rd_data_valid),
        .cmd_ready (rd_cmd_ready),
        .cmd_valid (rd_cmd_valid),
        .cmd_addr  (rd_cmd_addr),
        .inflight  (inflight)
    );

    mpc_capture #(.AW(AW), .DW(DW), .CW(CW)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (fresh),
        .hit        (miss),
        .hit_addr   (base_q + AW'(dat_idx)),
        .hit_expect (expect_w),
        .hit_actual (rd_data),
        .count      (stat_err_count),
        .err_addr   (stat_err_addr),
        .err_expect (stat_err_expect),
        .err_actual (stat_err_actual)
    );

    // Status levels.
    always_comb begin
        stat_done    = (state == ST_DONE) || (state == ST_HALT);
        stat_running = (state == ST_RUN);
    end
endmodule

// File: rtl/mem_pattern_checker_chk.sv
// Protocol and status checker for mem_pattern_checker, attached with bind.
// Assumes: clocked with the checker's clock and reset.
module mem_pattern_checker_chk #(
    parameter int AW      = 32,
    parameter int CW      = 16,
    parameter int MAX_OUT = 4,
    parameter int OCW     = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_start,
    input logic           rd_cmd_valid,
    input logic           rd_cmd_ready,
    input logic [AW-1:0]  rd_cmd_addr,
    input logic           stat_done,
    input logic           stat_running,
    input logic [CW-1:0]  stat_err_count,
    input logic [OCW-1:0] inflight
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !stat_done && !stat_running && stat_err_count == '0); // R1
    AST_DONE_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(stat_done && stat_running)); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) stat_done && !cfg_start |=> stat_done); // R8
    AST_CMD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n) rd_cmd_valid |-> stat_running); // R9
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid && !rd_cmd_ready |=> (rd_cmd_valid && $stable(rd_cmd_addr)) || !stat_running); // R9
    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) inflight <= OCW'(MAX_OUT)); // R9
    AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_start |=> stat_err_count >= $past(stat_err_count)); // R6
    AST_COUNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_err_count == '1 && !cfg_start |=> stat_err_count == '1); // R10
endmodule

bind mem_pattern_checker mem_pattern_checker_chk #(
    .AW(AW), .CW(CW), .MAX_OUT(MAX_OUT), .OCW(OCW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start      (cfg_start),
    .rd_cmd_valid   (rd_cmd_valid),
    .rd_cmd_ready   (rd_cmd_ready),
    .rd_cmd_addr    (rd_cmd_addr),
    .stat_done      (stat_done),
    .stat_running   (stat_running),
    .stat_err_count (stat_err_count),
    .inflight       (inflight)
);

// File: tb/sim_mem_pattern_checker.sv
// Directed bench: small memory model with two-cycle read latency and optional backpressure.
module sim_mem_pattern_checker;
    localparam int AW = 32, DW = 32, LW = 16, CW = 4;
    localparam logic [31:0] SEED = 32'h13579BDF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [LW-1:0] cfg_len = '0;
    logic          cfg_start = 1'b0;
    logic          cfg_halt_en = 1'b0;
    logic          rd_cmd_valid, rd_cmd_ready;
    logic [AW-1:0] rd_cmd_addr;
    logic          rd_data_valid;
    logic [DW-1:0] rd_data;
    logic          stat_done, stat_running;
    logic [CW-1:0] stat_err_count;
    logic [AW-1:0] stat_err_addr;
    logic [DW-1:0] stat_err_expect, stat_err_actual;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [64];
    logic [31:0] pat [64];
    logic        bp_mode = 1'b0;
    logic [1:0]  bp_cnt;
    logic        s0v, s1v;
    logic [5:0]  s0a, s1a;
    logic        mon_clr = 1'b1;
    logic [AW-1:0] mon_base = '0;
    int          mon_cnt;
    logic        mon_ok;

    always #5 clk = ~clk;

    mem_pattern_checker #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .MAX_OUT(4), .SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_start(cfg_start), .cfg_halt_en(cfg_halt_en),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
        .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .stat_done(stat_done), .stat_running(stat_running), .stat_err_count(stat_err_count),
        .stat_err_addr(stat_err_addr), .stat_err_expect(stat_err_expect), .stat_err_actual(stat_err_actual)
    );

    // Memory model: backpressure pattern and two-stage read pipeline.
    assign rd_cmd_ready  = !bp_mode || bp_cnt[1];
    assign rd_data_valid = s1v;
    assign rd_data       = mem[s1a];
    always @(posedge clk) begin
        if (!rst_n) begin
            bp_cnt <= '0; s0v <= 1'b0; s1v <= 1'b0; s0a <= '0; s1a <= '0;
        end else begin
            bp_cnt <= bp_cnt + 1'b1;
            s0v <= rd_cmd_valid && rd_cmd_ready;
            s0a <= rd_cmd_addr[5:0];
            s1v <= s0v;
            s1a <= s0a;
        end
    end

    // Command monitor: counts accepted commands and checks address order.
    always @(posedge clk) begin
        if (mon_clr) begin
            mon_cnt <= 0; mon_ok <= 1'b1;
        end else if (rd_cmd_valid && rd_cmd_ready) begin
            if (rd_cmd_addr != mon_base + AW'(mon_cnt)) mon_ok <= 1'b0;
            mon_cnt <= mon_cnt + 1;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic fill(input int base, input int len);
        for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD0000 + i;
        for (int i = 0; i < len; i++) mem[base + i] = pat[i];
    endtask

    task automatic start_run(input int base, input int len, input bit halt);
        @(negedge clk);
        cfg_base = AW'(base); cfg_len = LW'(len); cfg_halt_en = halt;
        mon_base = AW'(base); mon_clr = 1'b0;
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!stat_done) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_eq("R1 done", stat_done, 0);
        chk_eq("R1 running", stat_running, 0);
        chk_eq("R1 cmd_valid", rd_cmd_valid, 0);
        chk_eq("R1 count", stat_err_count, 0);
    endtask

    task automatic t_clean(input bit bp);
        bp_mode = bp; mon_clr = 1'b1;
        fill(16, 32);
        start_run(16, 32, 1'b0);
        wait_done();
        chk_eq("R3 clean count", stat_err_count, 0);
        chk_eq("R2 command count", mon_cnt, 32);
        chk_eq("R2 address order", mon_ok, 1);
        chk_eq("R9 running low at end", stat_running, 0);
        bp_mode = 1'b0; mon_clr = 1'b1;
    endtask

    task automatic t_no_halt();
        fill(16, 32);
        mem[20] = 32'h200;
        start_run(16, 32, 1'b0);
        wait_done();
        chk_eq("R4 one error count", stat_err_count, 1);
        chk_eq("R4 one error addr", stat_err_addr, 20);
        chk_eq("R4 one error expect", stat_err_expect, pat[4]);
        chk_eq("R4 one error actual", stat_err_actual, 32'h200);
        mem[21] = 32'h210;
        start_run(16, 32, 1'b0);
        wait_done();
        chk_eq("R7 fresh run recounts", stat_err_count, 2);
        chk_eq("R4 latest addr", stat_err_addr, 21);
        chk_eq("R4 latest expect", stat_err_expect, pat[5]);
    endtask

    task automatic t_halt();
        fill(16, 32);
        mem[20] = 32'h200; mem[21] = 32'h210;
        start_run(16, 32, 1'b1);
        wait_done();
        chk_eq("R5 halt running", stat_running, 0);
        chk_eq("R5 halt count", stat_err_count, 1);
        chk_eq("R5 halt addr", stat_err_addr, 20);
        chk_eq("R5 halt expect", stat_err_expect, pat[4]);
        chk_eq("R5 halt actual", stat_err_actual, 32'h200);
        repeat (10) @(negedge clk);
        chk_eq("R8 done held while halted", stat_done, 1);
        start_run(16, 32, 1'b1);
        wait_done();
        chk_eq("R6 resume count", stat_err_count, 2);
        chk_eq("R6 resume addr", stat_err_addr, 21);
        chk_eq("R6 resume expect", stat_err_expect, pat[5]);
        chk_eq("R6 resume actual", stat_err_actual, 32'h210);
        start_run(16, 32, 1'b1);
        wait_done();
        chk_eq("R6 finish count", stat_err_count, 2);
        chk_eq("R6 finish addr", stat_err_addr, 21);
        start_run(16, 32, 1'b0);
        wait_done();
        chk_eq("R7 fresh after finish count", stat_err_count, 2);
    endtask

    task automatic t_start_ignored();
        fill(16, 32);
        mem[40] = 32'h55;
        start_run(16, 32, 1'b0);
        repeat (5) @(negedge clk);
        cfg_start = 1'b1; cfg_base = 0; cfg_len = 3;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_done();
        chk_eq("R8 start ignored count", stat_err_count, 1);
        chk_eq("R8 start ignored addr", stat_err_addr, 40);
        repeat (8) @(negedge clk);
        chk_eq("R8 done level", stat_done, 1);
    endtask

    task automatic t_zero_len();
        mon_clr = 1'b1;
        start_run(8, 0, 1'b0);
        repeat (2) @(negedge clk);
        chk_eq("R2 zero length done", stat_done, 1);
        chk_eq("R2 zero length commands", mon_cnt, 0);
        mon_clr = 1'b1;
    endtask

    task automatic t_saturate();
        fill(0, 40);
        for (int i = 0; i < 20; i++) mem[i] = ~pat[i];
        start_run(0, 40, 1'b0);
        wait_done();
        chk_eq("R10 saturated count", stat_err_count, 15);
        chk_eq("R10 last addr", stat_err_addr, 19);
    endtask

    initial begin
        pat[0] = SEED;
        for (int i = 1; i < 64; i++)
            pat[i] = {pat[i-1][30:0], pat[i-1][31] ^ pat[i-1][21] ^ pat[i-1][1] ^ pat[i-1][0]};
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(1'b0);
        t_clean(1'b1);
        t_no_halt();
        t_halt();
        t_start_ignored();
        t_zero_len();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule